// File: doc/BRIEF.md
# Long-press reset controller

This block turns one or two active-low push-button inputs into a system reset request. Nothing happens on a short press. Reset is asserted only after every monitored button has been held down at the same time for a long setup period. A static select input chooses between two setup periods, and one of them may be zero for factory test. A build-time parameter chooses how the reset ends. In fixed-pulse mode it lasts a set width whatever the buttons do. In release mode it ends as soon as any button lets go.

Each valid hold produces exactly one reset. The buttons must be released and then held again for a full setup period before the block can fire again. After power-on, the block waits through a short start-up interval before it looks at the buttons. The select input is taken only while the block is starting up or while some button is up, so changing it in the middle of a hold has no effect on that hold.

All durations are whole numbers of ticks. A tick is derived from the clock frequency and a tick period, both given as parameters. The output models an open-drain pin: one port is the pull-down enable, and the other is the level the line would show with an external pull-up.

Top module: `lpr_longpress_rst`

## Requirements
- R1: While `rst_n` is low, `rstDriveLow` is 0 and `rstLine_n` is 1.
- R2: After `rst_n` rises, the buttons are ignored for STARTUP_TICKS ticks. If the buttons are already low, the first drive-low appears on edge STARTUP_TICKS*T + H*T + 3 after release, where T is the tick length in clocks and H is the selected hold in ticks.
- R3: Reset asserts only when all monitored buttons are low (0 = pressed) together for H*T cycles. Counting the edge that first samples the last button going low as edge 0, the drive-low appears after edge H*T+3. A single button held low in a two-button build never fires.
- R4: If any monitored button goes high before the hold completes, timing is abandoned. A new hold needs the full period, measured from the new press.
- R5: `delaySel` = 0 selects HOLD_LO_TICKS and `delaySel` = 1 selects HOLD_HI_TICKS. A zero hold fires three edges after the press is first sampled.
- R6: The select value is taken only during start-up or while at least one monitored button is high. A change made during a hold applies from the next hold onwards.
- R7: In fixed-pulse mode, `rstDriveLow` stays high for exactly PULSE_TICKS*T+1 cycles, whatever the buttons do during the pulse.
- R8: In release mode, `rstDriveLow` falls on the second edge after a monitored button returns high. A hold of d cycles therefore gives a pulse of d-H*T-1 cycles.
- R9: Each valid hold gives a single pulse. Buttons kept low after a fixed pulse produce no further pulse.
- R10: A low-high-low glitch during a fixed pulse is not seen and does not rearm the block. A button that is high when the pulse ends rearms it, so the next full hold fires again.
- R11: With NUM_BUTTONS = 1, the single button alone decides both the hold and the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pbIn_n | input | NUM_BUTTONS | Push-button levels, 0 = pressed, unsynchronised |
| delaySel | input | 1 | Setup-period select, meant to be static |
| rstDriveLow | output | 1 | Open-drain pull-down enable, 1 = reset asserted |
| rstLine_n | output | 1 | Line level seen with an external pull-up |

## Verification
Every result here falls a fixed number of edges after the stimulus. Assertion appears H*T+3 edges after the first sampling edge of a press: two of those edges are spent in the synchroniser and one entering timing. A release ends a release-mode pulse two edges later, and a fixed pulse lasts PULSE_TICKS*T+1 samples. The bench drives and samples one time unit after each rising edge and counts edges from the drive. It compares the edge of the first drive-low, the number of pulses and the last pulse width against those formulas, computed in bench functions. It applies the formulas to directed corner cases and to random press lengths placed on both sides of the firing threshold.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  typedef enum logic [2:0] {
    ST_STARTUP,
    ST_IDLE,
    ST_TIMING,
    ST_RESET,
    ST_WAIT_RELEASE
  } lprState_e;

  typedef enum logic [1:0] {
    TMR_STARTUP,
    TMR_HOLD,
    TMR_PULSE
  } tmrSel_e;

  // Strobes from control to the timing datapath
  typedef struct packed {
    logic    clrTimer;
    tmrSel_e tmrSel;
    logic    selCapture;
  } lprStrobe_t;

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int               WIDTH       = 1,
  parameter logic [WIDTH-1:0] RESET_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    logic metaQ;
    logic stableQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        metaQ   <= RESET_VALUE[i];
        stableQ <= RESET_VALUE[i];
      end else begin
        metaQ   <= asyncIn[i];
        stableQ <= metaQ;
      end
    end
    assign syncOut[i] = stableQ;
  end

endmodule

// File: rtl/lpr_timer.sv
module lpr_timer
  import lpr_pkg::*;
#(
  parameter int TICK_CYCLES   = 10000,
  parameter int STARTUP_TICKS = 3,
  parameter int HOLD_LO_TICKS = 75000,
  parameter int HOLD_HI_TICKS = 0,
  parameter int PULSE_TICKS   = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  lprStrobe_t strobe,
  input  logic       selSync,
  output logic       timerDone,
  output logic       selLatched
);

  localparam int MAX_A     = (STARTUP_TICKS > PULSE_TICKS) ? STARTUP_TICKS : PULSE_TICKS;
  localparam int MAX_B     = (HOLD_LO_TICKS > HOLD_HI_TICKS) ? HOLD_LO_TICKS : HOLD_HI_TICKS;
  localparam int MAX_TICKS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW        = (MAX_TICKS > 0) ? $clog2(MAX_TICKS + 1) : 1;
  localparam int CW        = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  localparam logic [CW-1:0] CYC_LAST  = CW'(TICK_CYCLES - 1);
  localparam logic [TW-1:0] T_STARTUP = TW'(STARTUP_TICKS);
  localparam logic [TW-1:0] T_HOLD_LO = TW'(HOLD_LO_TICKS);
  localparam logic [TW-1:0] T_HOLD_HI = TW'(HOLD_HI_TICKS);
  localparam logic [TW-1:0] T_PULSE   = TW'(PULSE_TICKS);
  localparam logic [TW-1:0] T_CEIL    = TW'(MAX_TICKS);

  logic [CW-1:0] cycCnt;
  logic [TW-1:0] tickCnt;
  logic [TW-1:0] target;
  logic          tickWrap;

  assign tickWrap = (cycCnt == CYC_LAST);

  always_comb begin
    unique case (strobe.tmrSel)
      TMR_STARTUP: target = T_STARTUP;
      TMR_PULSE:   target = T_PULSE;
      default:     target = selLatched ? T_HOLD_HI : T_HOLD_LO;
    endcase
  end

  // Prescaler restarts with each interval so every duration is exact
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycCnt <= '0;
    end else if (strobe.clrTimer || tickWrap) begin
      cycCnt <= '0;
    end else begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt <= '0;
    end else if (strobe.clrTimer) begin
      tickCnt <= '0;
    end else if (tickWrap && (tickCnt != T_CEIL)) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selLatched <= 1'b0;
    end else if (strobe.selCapture) begin
      selLatched <= selSync;
    end
  end

  assign timerDone = (tickCnt == target);

  // prescaler never leaves its range
  cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycCnt <= CYC_LAST);

endmodule

// File: rtl/lpr_ctrl.sv
module lpr_ctrl
  import lpr_pkg::*;
#(
  parameter int NUM_BUTTONS = 2,
  parameter bit FIXED_PULSE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BUTTONS-1:0] btnSync,
  input  logic                   timerDone,
  output lprStrobe_t             strobe,
  output lprState_e              state,
  output logic                   driveLow
);

  lprState_e stateNext;
  logic      allLow;

  assign allLow = ~|btnSync;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_STARTUP: if (timerDone) stateNext = ST_IDLE;
      ST_IDLE:    if (allLow) stateNext = ST_TIMING;
      ST_TIMING: begin
        if (!allLow)        stateNext = ST_IDLE;
        else if (timerDone) stateNext = ST_RESET;
      end
      ST_RESET: begin
        if (FIXED_PULSE) begin
          if (timerDone) stateNext = ST_WAIT_RELEASE;
        end else if (!allLow) begin
          stateNext = ST_IDLE;
        end
      end
      ST_WAIT_RELEASE: if (!allLow) stateNext = ST_IDLE;
      default:         stateNext = ST_STARTUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_STARTUP;
    else        state <= stateNext;
  end

  always_comb begin
    strobe.clrTimer   = (stateNext != state);
    strobe.selCapture = (state == ST_STARTUP) || !allLow;
    unique case (state)
      ST_STARTUP: strobe.tmrSel = TMR_STARTUP;
      ST_RESET:   strobe.tmrSel = TMR_PULSE;
      default:    strobe.tmrSel = TMR_HOLD;
    endcase
  end

  assign driveLow = (state == ST_RESET);

  // R2
  startup_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STARTUP && !timerDone) |=> (state == ST_STARTUP));

  // R3
  idle_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> !driveLow);

  // R4
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TIMING && !allLow) |=> (state == ST_IDLE));

  // R9
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_RELEASE) |=> !driveLow);

  if (FIXED_PULSE) begin : gFixedChk
    // R7
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (driveLow && !timerDone) |=> driveLow);
  end else begin : gReleaseChk
    // R8
    release_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (driveLow && !allLow) |=> !driveLow);
  end

endmodule

// File: rtl/lpr_longpress_rst.sv
module lpr_longpress_rst
  import lpr_pkg::*;
#(
  parameter int NUM_BUTTONS   = 2,
  parameter bit FIXED_PULSE   = 1'b1,
  parameter int CLK_KHZ       = 100000,
  parameter int TICK_US       = 100,
  parameter int STARTUP_TICKS = 3,
  parameter int HOLD_LO_TICKS = 75000,
  parameter int HOLD_HI_TICKS = 0,
  parameter int PULSE_TICKS   = 4000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BUTTONS-1:0] pbIn_n,
  input  logic                   delaySel,
  output logic                   rstDriveLow,
  output logic                   rstLine_n
);

  localparam int TICK_CYCLES = (CLK_KHZ * TICK_US / 1000 > 0) ? CLK_KHZ * TICK_US / 1000 : 1;

  logic [NUM_BUTTONS-1:0] btnSync;
  logic [0:0]             selSyncV;
  logic                   timerDone;
  logic                   selLatched;
  logic                   btnAllLow;
  lprStrobe_t             strobe;
  lprState_e              ctrlState;

  lpr_sync #(.WIDTH(NUM_BUTTONS), .RESET_VALUE({NUM_BUTTONS{1'b1}})) btnSync_i (
    .clk(clk), .rst_n(rst_n), .asyncIn(pbIn_n), .syncOut(btnSync)
  );

  lpr_sync #(.WIDTH(1), .RESET_VALUE(1'b0)) selSync_i (
    .clk(clk), .rst_n(rst_n), .asyncIn(delaySel), .syncOut(selSyncV)
  );

  lpr_timer #(
    .TICK_CYCLES(TICK_CYCLES), .STARTUP_TICKS(STARTUP_TICKS),
    .HOLD_LO_TICKS(HOLD_LO_TICKS), .HOLD_HI_TICKS(HOLD_HI_TICKS),
    .PULSE_TICKS(PULSE_TICKS)
  ) timer_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .selSync(selSyncV[0]),
    .timerDone(timerDone), .selLatched(selLatched)
  );

  lpr_ctrl #(.NUM_BUTTONS(NUM_BUTTONS), .FIXED_PULSE(FIXED_PULSE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .btnSync(btnSync), .timerDone(timerDone),
    .strobe(strobe), .state(ctrlState), .driveLow(rstDriveLow)
  );

  assign rstLine_n = ~rstDriveLow;
  assign btnAllLow = ~|btnSync;

  // R6
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlState == ST_TIMING && btnAllLow) |=> $stable(selLatched));

endmodule

// File: tb/lpr_longpress_rst_tb_top.sv
`timescale 1ns/1ps
module lpr_longpress_rst_tb_top;

  localparam int T        = 4;   // clocks per tick in both instances
  localparam int FIX_S    = 5;
  localparam int FIX_HLO  = 10;
  localparam int FIX_HHI  = 0;
  localparam int FIX_P    = 6;
  localparam int REL_HLO  = 8;
  localparam int REL_HHI  = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pbFix = 2'b00;
  logic       selFix = 1'b0;
  logic [0:0] pbRel = 1'b1;
  logic       selRel = 1'b0;
  logic       fixLow, fixLine_n, relLow, relLine_n;

  int tests = 0, fails = 0;
  bit finished = 0;
  int fixRises = 0, relRises = 0, fixWidth = 0, relWidth = 0;
  int fixLastWidth = 0, relLastWidth = 0;
  bit fixPrev = 0, relPrev = 0;

  always #5 clk = ~clk;

  lpr_longpress_rst #(
    .NUM_BUTTONS(2), .FIXED_PULSE(1'b1), .CLK_KHZ(4000), .TICK_US(1),
    .STARTUP_TICKS(FIX_S), .HOLD_LO_TICKS(FIX_HLO), .HOLD_HI_TICKS(FIX_HHI),
    .PULSE_TICKS(FIX_P)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pbIn_n(pbFix), .delaySel(selFix),
    .rstDriveLow(fixLow), .rstLine_n(fixLine_n)
  );

  lpr_longpress_rst #(
    .NUM_BUTTONS(1), .FIXED_PULSE(1'b0), .CLK_KHZ(4000), .TICK_US(1),
    .STARTUP_TICKS(FIX_S), .HOLD_LO_TICKS(REL_HLO), .HOLD_HI_TICKS(REL_HHI),
    .PULSE_TICKS(FIX_P)
  ) dutRel_i (
    .clk(clk), .rst_n(rst_n), .pbIn_n(pbRel), .delaySel(selRel),
    .rstDriveLow(relLow), .rstLine_n(relLine_n)
  );

  // expected values from the requirements
  function automatic int fireEdge(int h);
    return h * T + 4;          // counted in samples after the drive
  endfunction
  function automatic int fires(int d, int h);
    return (d >= h * T + 2) ? 1 : 0;
  endfunction
  function automatic int relPulse(int d, int h);
    return d - h * T - 1;
  endfunction
  function automatic int fixPulse();
    return FIX_P * T + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    if (fixLow) begin
      if (!fixPrev) begin fixRises++; fixWidth = 0; end
      fixWidth++;
    end else if (fixPrev) fixLastWidth = fixWidth;
    if (relLow) begin
      if (!relPrev) begin relRises++; relWidth = 0; end
      relWidth++;
    end else if (relPrev) relLastWidth = relWidth;
    fixPrev = fixLow;
    relPrev = relLow;
  endtask

  task automatic idle(int n);
    repeat (n) cyc();
  endtask

  task automatic waitRise(bit useRel, int maxc, output int k);
    int r0;
    r0 = useRel ? relRises : fixRises;
    k = 0;
    for (int i = 1; i <= maxc; i++) begin
      cyc();
      if ((useRel ? relRises : fixRises) != r0) begin
        k = i;
        break;
      end
    end
  endtask

  initial begin
    int k, r0, d, s;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R1 outputs released while in reset
    chk("R1", fixLow, 0);
    chk("R1", fixLine_n, 1);
    chk("R1", relLow, 0);
    rst_n = 1'b1;
    // R2 buttons already low at power-up
    waitRise(0, 120, k);
    chk("R2", k, FIX_S * T + FIX_HLO * T + 3);
    idle(30);
    chk("R7", fixLastWidth, fixPulse());
    idle(100);
    chk("R9", fixRises, 1);
    pbFix = 2'b11; idle(10);

    // R3 staggered press counts from the last button
    pbFix = 2'b10; idle(20);
    pbFix = 2'b00;
    waitRise(0, 80, k);
    chk("R3", k, fireEdge(FIX_HLO));
    idle(30); pbFix = 2'b11; idle(10);

    // R3 one button alone never fires
    r0 = fixRises;
    pbFix = 2'b10; idle(150);
    chk("R3", fixRises - r0, 0);
    pbFix = 2'b11; idle(10);

    // R4 one-cycle release restarts timing
    pbFix = 2'b00; idle(30);
    pbFix = 2'b01; cyc();
    pbFix = 2'b00;
    waitRise(0, 80, k);
    chk("R4", k, fireEdge(FIX_HLO));
    idle(30); pbFix = 2'b11; idle(10);

    // R10 glitch during pulse is ignored
    pbFix = 2'b00;
    waitRise(0, 80, k);
    idle(3);
    pbFix = 2'b10; idle(2);
    pbFix = 2'b00;
    r0 = fixRises;
    idle(100);
    chk("R7", fixLastWidth, fixPulse());
    chk("R10", fixRises - r0, 0);
    pbFix = 2'b11; idle(10);

    // R10 release during pulse rearms after it
    pbFix = 2'b00;
    waitRise(0, 80, k);
    idle(4);
    pbFix = 2'b11; idle(40);
    chk("R7", fixLastWidth, fixPulse());
    pbFix = 2'b00;
    waitRise(0, 80, k);
    chk("R10", k, fireEdge(FIX_HLO));
    idle(30); pbFix = 2'b11; idle(10);

    // R5 zero hold with select high
    selFix = 1'b1; idle(8);
    pbFix = 2'b00;
    waitRise(0, 30, k);
    chk("R5", k, fireEdge(FIX_HHI));
    idle(30);
    chk("R7", fixLastWidth, fixPulse());
    pbFix = 2'b11; selFix = 1'b0; idle(10);

    // R6 select change mid-hold takes effect next hold
    pbFix = 2'b00; idle(10);
    selFix = 1'b1;
    waitRise(0, 80, k);
    chk("R6", k, fireEdge(FIX_HLO) - 10);
    idle(30); pbFix = 2'b11; idle(10);
    pbFix = 2'b00;
    waitRise(0, 30, k);
    chk("R6", k, fireEdge(FIX_HHI));
    idle(30); pbFix = 2'b11; selFix = 1'b0; idle(10);

    // R3 random press lengths around the threshold
    for (int t = 0; t < 20; t++) begin
      d = 30 + $urandom_range(0, 25);
      s = $urandom_range(0, 10);
      r0 = fixRises;
      pbFix = ($urandom_range(0, 1) != 0) ? 2'b10 : 2'b01;
      idle(s);
      pbFix = 2'b00; idle(d);
      pbFix = 2'b11; idle(40);
      chk("R3", fixRises - r0, fires(d, FIX_HLO));
    end

    // R11 single button alone fires
    pbRel = 1'b0;
    waitRise(1, 60, k);
    chk("R11", k, fireEdge(REL_HLO));
    idle(5); pbRel = 1'b1; idle(10);

    // R5 release instance, long hold with select high
    selRel = 1'b1; idle(8);
    pbRel = 1'b0;
    waitRise(1, 100, k);
    chk("R5", k, fireEdge(REL_HHI));
    idle(5); pbRel = 1'b1; selRel = 1'b0; idle(10);

    // R8 random holds, pulse ends on release
    for (int t = 0; t < 15; t++) begin
      d = 25 + $urandom_range(0, 45);
      r0 = relRises;
      pbRel = 1'b0; idle(d);
      pbRel = 1'b1; idle(6);
      chk("R8", relRises - r0, fires(d, REL_HLO));
      if (fires(d, REL_HLO) != 0) chk("R8", relLastWidth, relPulse(d, REL_HLO));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule